// File: doc/BRIEF.md
# Level-to-Message Interrupt Notifier

This block turns up to twenty level-sensitive interrupt sources into posted memory-write messages. Each source reports its current level through a narrow indexed update port (index, state, strobe). The block keeps the latest level of every source in a level register. A low-to-high change marks the source as pending. Pending sources are drained one at a time into a message made of a 64-bit target address and a 64-bit payload. The message is offered on a valid/ready channel toward the fabric.

Software sets the block up through a 64-bit register port with byte offsets. The address register holds the message target and an enable flag in its top bit. The offset register supplies, in its upper half, a base number that is ORed with the source index to form a global interrupt number. The control register selects between message signalling and level signalling, and has a self-clearing bit that wipes all per-source state.

Top module: `lmn_notifier`

## Requirements
- R1: After reset every configuration register and the level register read zero, `msg_valid` is low and `src_err` is low.
- R2: Byte offsets 0x58 (control), 0x60 (buffer base), 0x68 (notify address) and 0x70 (number offset) read back what was last written, except control bit 62, which reads 0. Offset 0x78 (level) is read-only, and writes to it have no effect. Any other offset reads 64'hFFFF_FFFF_FFFF_FFFF.
- R3: A valid update with index n below 20 and control bit 63 clear sets bit (63 - n) of the level register to the update's state. Source 0 maps to bit 63.
- R4: A low-to-high update of source n, with notify address bit 63 set, produces exactly one message. Its address is the notify address with bit 63 cleared. Its data is (1 << 60) | offset[63:32] | n, where the fields are ORed and not added. A high-to-high or a falling update produces no message.
- R5: While notify address bit 63 is clear, a rising update updates the level register but is discarded, so setting bit 63 again produces no message for it.
- R6: While control bit 63 (level-signalling method) is set, updates are ignored: the level register keeps its value and no message is produced.
- R7: A control write with bit 62 set clears the level register and every pending source. The other written bits are stored. A message already offered stays offered.
- R8: Sources pending at the same time are sent lowest index first, each exactly once.
- R9: While `msg_valid` is high and `msg_ready` is low, `msg_valid`, `msg_addr` and `msg_data` stay unchanged.
- R10: An update whose index is 20 or more raises `src_err` for the cycle after it and changes no level or pending state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_upd_valid | input | 1 | Level update strobe |
| src_upd_idx | input | 5 | Source index of the update |
| src_upd_state | input | 1 | New level of that source |
| src_err | output | 1 | One-cycle pulse for an out-of-range index |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data for `reg_addr` |
| msg_valid | output | 1 | Message offered |
| msg_ready | input | 1 | Fabric accepts the message |
| msg_addr | output | 64 | Message target address |
| msg_data | output | 64 | Message payload |

## Verification
The bench uses an offset whose low bits overlap the source index. A design that added the two fields instead of ORing them would emit a wrong payload. Repeated and falling levels are mixed with real rises, so a design that fired on level instead of edge would send extra messages. Several sources are queued behind a stalled channel: a design that drained them out of order, dropped one, or let the held message change under backpressure would be caught. The bench also covers the source-reset write, method-bit freezing, the disabled-notify discard and out-of-range indices. A design that leaked state through any of these would show a level bit, a message or an error pulse where none belongs.

// File: rtl/lmn_pkg.sv
package lmn_pkg;

    // register byte offsets
    localparam logic [7:0] OFF_CTRL  = 8'h58;
    localparam logic [7:0] OFF_EBASE = 8'h60;
    localparam logic [7:0] OFF_NADDR = 8'h68;
    localparam logic [7:0] OFF_IOFF  = 8'h70;
    localparam logic [7:0] OFF_LEVEL = 8'h78;

    // bit positions
    localparam int CTRL_METHOD = 63;
    localparam int CTRL_SRST   = 62;
    localparam int NADDR_VLD   = 63;

    typedef struct packed {
        logic [63:0] ctrl;
        logic [63:0] ebase;
        logic [63:0] naddr;
        logic [63:0] ioff;
    } cfg_t;

    typedef struct packed {
        logic        vld;
        logic [63:0] addr;
        logic [63:0] data;
    } msg_t;

endpackage

// File: rtl/lmn_cfg_regs.sv
module lmn_cfg_regs
    import lmn_pkg::*;
#(
    parameter int REG_AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] addr,
    input  logic [63:0]       wdata,
    input  logic [63:0]       level_vec,
    output logic              method_o,
    output logic              notify_en_o,
    output logic [63:0]       naddr_o,
    output logic [31:0]       ioff_hi_o,
    output logic              src_clr_o,
    output logic [63:0]       rdata_o
);

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d     = cfg_q;
        src_clr_o = 1'b0;
        if (wr_en) begin
            case (addr)
                REG_AW'(OFF_CTRL): begin
                    cfg_d.ctrl            = wdata;
                    cfg_d.ctrl[CTRL_SRST] = 1'b0;
                    src_clr_o             = wdata[CTRL_SRST];
                end
                REG_AW'(OFF_EBASE): cfg_d.ebase = wdata;
                REG_AW'(OFF_NADDR): cfg_d.naddr = wdata;
                REG_AW'(OFF_IOFF):  cfg_d.ioff  = wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (addr)
            REG_AW'(OFF_CTRL):  rdata_o = cfg_q.ctrl;
            REG_AW'(OFF_EBASE): rdata_o = cfg_q.ebase;
            REG_AW'(OFF_NADDR): rdata_o = cfg_q.naddr;
            REG_AW'(OFF_IOFF):  rdata_o = cfg_q.ioff;
            REG_AW'(OFF_LEVEL): rdata_o = level_vec;
            default:            rdata_o = '1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign method_o    = cfg_q.ctrl[CTRL_METHOD];
    assign notify_en_o = cfg_q.naddr[NADDR_VLD];
    assign naddr_o     = cfg_q.naddr;
    assign ioff_hi_o   = cfg_q.ioff[63:32];

endmodule

// File: rtl/lmn_src_track.sv
module lmn_src_track #(
    parameter int NUM_SRC = 20,
    parameter int IDX_W   = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               upd_valid,
    input  logic [IDX_W-1:0]   upd_idx,
    input  logic               upd_state,
    input  logic               method,
    input  logic               notify_en,
    input  logic               src_clr,
    input  logic [NUM_SRC-1:0] grant,
    output logic [NUM_SRC-1:0] level_o,
    output logic [NUM_SRC-1:0] pend_o,
    output logic               err_o
);

    typedef struct packed {
        logic [NUM_SRC-1:0] level;
        logic [NUM_SRC-1:0] pend;
        logic               err;
    } trk_t;

    trk_t trk_d, trk_q;
    logic idx_ok;

    always_comb begin
        idx_ok     = (int'(upd_idx) < NUM_SRC);
        trk_d      = trk_q;
        trk_d.err  = 1'b0;
        trk_d.pend = trk_q.pend & ~grant;
        if (upd_valid && !idx_ok) begin
            trk_d.err = 1'b1;
        end else if (upd_valid && !method) begin
            for (int i = 0; i < NUM_SRC; i++) begin
                if (upd_idx == IDX_W'(i)) begin
                    if (upd_state && !trk_q.level[i] && notify_en)
                        trk_d.pend[i] = 1'b1;
                    trk_d.level[i] = upd_state;
                end
            end
        end
        if (src_clr) begin
            trk_d.level = '0;
            trk_d.pend  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

    assign level_o = trk_q.level;
    assign pend_o  = trk_q.pend;
    assign err_o   = trk_q.err;

endmodule

// File: rtl/lmn_pick.sv
module lmn_pick #(
    parameter int NUM_SRC = 20,
    parameter int IDX_W   = 5
) (
    input  logic [NUM_SRC-1:0] pend,
    output logic               found_o,
    output logic [IDX_W-1:0]   idx_o,
    output logic [NUM_SRC-1:0] onehot_o
);

    // scan high to low so the lowest set index is the last to win
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (pend[i]) begin
                found_o = 1'b1;
                idx_o   = IDX_W'(i);
            end
        end
        onehot_o = found_o ? (NUM_SRC'(1) << idx_o) : '0;
    end

endmodule

// File: rtl/lmn_msg_out.sv
module lmn_msg_out
    import lmn_pkg::*;
#(
    parameter int IDX_W    = 5,
    parameter int TRIG_BIT = 60
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_found,
    input  logic [IDX_W-1:0] req_idx,
    input  logic [63:0]      naddr,
    input  logic [31:0]      ioff_hi,
    input  logic             ready,
    output logic             take_o,
    output logic             valid_o,
    output logic [63:0]      addr_o,
    output logic [63:0]      data_o
);

    localparam logic [63:0] TRIG_CODE = 64'(1) << TRIG_BIT;
    localparam logic [63:0] VLD_MASK  = 64'(1) << NADDR_VLD;

    msg_t msg_d, msg_q;

    always_comb begin
        take_o = req_found && naddr[NADDR_VLD] && !msg_q.vld;
        msg_d  = msg_q;
        if (msg_q.vld && ready)
            msg_d.vld = 1'b0;
        if (take_o) begin
            msg_d.vld  = 1'b1;
            msg_d.addr = naddr & ~VLD_MASK;
            msg_d.data = TRIG_CODE | {32'h0, ioff_hi} | 64'(req_idx);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) msg_q <= '0;
        else        msg_q <= msg_d;
    end

    assign valid_o = msg_q.vld;
    assign addr_o  = msg_q.addr;
    assign data_o  = msg_q.data;

endmodule

// File: rtl/lmn_notifier.sv
module lmn_notifier
    import lmn_pkg::*;
#(
    parameter int NUM_SRC  = 20,
    parameter int IDX_W    = 5,
    parameter int REG_AW   = 8,
    parameter int TRIG_BIT = 60
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              src_upd_valid,
    input  logic [IDX_W-1:0]  src_upd_idx,
    input  logic              src_upd_state,
    output logic              src_err,
    input  logic              reg_wr_en,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [63:0]       reg_wdata,
    output logic [63:0]       reg_rdata,
    output logic              msg_valid,
    input  logic              msg_ready,
    output logic [63:0]       msg_addr,
    output logic [63:0]       msg_data
);

    localparam int LVL_W = 64;

    logic               method;
    logic               notify_en;
    logic [63:0]        naddr;
    logic [31:0]        ioff_hi;
    logic               src_clr;
    logic [LVL_W-1:0]   level_vec;
    logic [NUM_SRC-1:0] level_q;
    logic [NUM_SRC-1:0] pend_q;
    logic [NUM_SRC-1:0] pick_onehot;
    logic [NUM_SRC-1:0] grant;
    logic [IDX_W-1:0]   pick_idx;
    logic               pick_found;
    logic               take;

    // source n occupies bit (63 - n)
    always_comb begin
        level_vec = '0;
        for (int n = 0; n < NUM_SRC; n++)
            level_vec[LVL_W-1-n] = level_q[n];
    end

    assign grant = take ? pick_onehot : '0;

    lmn_cfg_regs #(.REG_AW(REG_AW)) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (reg_wr_en),
        .addr        (reg_addr),
        .wdata       (reg_wdata),
        .level_vec   (level_vec),
        .method_o    (method),
        .notify_en_o (notify_en),
        .naddr_o     (naddr),
        .ioff_hi_o   (ioff_hi),
        .src_clr_o   (src_clr),
        .rdata_o     (reg_rdata)
    );

    lmn_src_track #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_trk (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_valid (src_upd_valid),
        .upd_idx   (src_upd_idx),
        .upd_state (src_upd_state),
        .method    (method),
        .notify_en (notify_en),
        .src_clr   (src_clr),
        .grant     (grant),
        .level_o   (level_q),
        .pend_o    (pend_q),
        .err_o     (src_err)
    );

    lmn_pick #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_pick (
        .pend     (pend_q),
        .found_o  (pick_found),
        .idx_o    (pick_idx),
        .onehot_o (pick_onehot)
    );

    lmn_msg_out #(.IDX_W(IDX_W), .TRIG_BIT(TRIG_BIT)) u_msg (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_found (pick_found),
        .req_idx   (pick_idx),
        .naddr     (naddr),
        .ioff_hi   (ioff_hi),
        .ready     (msg_ready),
        .take_o    (take),
        .valid_o   (msg_valid),
        .addr_o    (msg_addr),
        .data_o    (msg_data)
    );

endmodule

// File: rtl/lmn_notifier_chk.sv
module lmn_notifier_chk
    import lmn_pkg::*;
#(
    parameter int NUM_SRC  = 20,
    parameter int IDX_W    = 5,
    parameter int REG_AW   = 8,
    parameter int TRIG_BIT = 60
) (
    input logic               clk,
    input logic               rst_n,
    input logic               src_upd_valid,
    input logic [IDX_W-1:0]   src_upd_idx,
    input logic               src_err,
    input logic               reg_wr_en,
    input logic [REG_AW-1:0]  reg_addr,
    input logic [63:0]        reg_wdata,
    input logic               method,
    input logic [NUM_SRC-1:0] level_q,
    input logic [NUM_SRC-1:0] pend_q,
    input logic               msg_valid,
    input logic               msg_ready,
    input logic [63:0]        msg_addr,
    input logic [63:0]        msg_data
);

    logic clr_wr;
    assign clr_wr = reg_wr_en && (reg_addr == REG_AW'(OFF_CTRL)) && reg_wdata[CTRL_SRST];

    // R9: offered message holds until accepted
    a_r9_msg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && !msg_ready |=> msg_valid && $stable(msg_addr) && $stable(msg_data));

    // R4: address never carries the enable flag
    a_r4_addr_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> !msg_addr[NADDR_VLD]);

    // R4: payload carries the trigger code
    a_r4_trig_code: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> msg_data[TRIG_BIT]);

    // R10: error pulse only after an out-of-range update
    a_r10_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
        src_err |-> $past(src_upd_valid) && (int'($past(src_upd_idx)) >= NUM_SRC));

    // R6: method bit freezes the level state
    a_r6_method_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        method && !clr_wr |=> $stable(level_q));

    // R7: source-reset write empties levels and pending
    a_r7_src_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> (level_q == '0) && (pend_q == '0));

endmodule

bind lmn_notifier lmn_notifier_chk #(
    .NUM_SRC(NUM_SRC), .IDX_W(IDX_W), .REG_AW(REG_AW), .TRIG_BIT(TRIG_BIT)
) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .src_upd_valid (src_upd_valid),
    .src_upd_idx   (src_upd_idx),
    .src_err       (src_err),
    .reg_wr_en     (reg_wr_en),
    .reg_addr      (reg_addr),
    .reg_wdata     (reg_wdata),
    .method        (method),
    .level_q       (level_q),
    .pend_q        (pend_q),
    .msg_valid     (msg_valid),
    .msg_ready     (msg_ready),
    .msg_addr      (msg_addr),
    .msg_data      (msg_data)
);

// File: tb/lmn_notifier_tb_top.sv
module lmn_notifier_tb_top;

    localparam int NUM_SRC  = 20;
    localparam int IDX_W    = 5;
    localparam int REG_AW   = 8;
    localparam int TRIG_BIT = 60;

    localparam logic [63:0] NADDR_ON  = 64'h8000_0000_C000_1000;
    localparam logic [63:0] NADDR_OFF = 64'h0000_0000_C000_1000;
    localparam logic [63:0] IOFF      = 64'h0000_0A0C_1234_5678;

    // table: {idx[4:0], state, expect_message}
    localparam logic [6:0] VECS [0:6] = '{
        {5'd5,  1'b1, 1'b1},
        {5'd5,  1'b1, 1'b0},
        {5'd19, 1'b1, 1'b1},
        {5'd5,  1'b0, 1'b0},
        {5'd0,  1'b1, 1'b1},
        {5'd5,  1'b1, 1'b1},
        {5'd19, 1'b0, 1'b0}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              src_upd_valid = 1'b0;
    logic [IDX_W-1:0]  src_upd_idx = '0;
    logic              src_upd_state = 1'b0;
    logic              src_err;
    logic              reg_wr_en = 1'b0;
    logic [REG_AW-1:0] reg_addr = '0;
    logic [63:0]       reg_wdata = '0;
    logic [63:0]       reg_rdata;
    logic              msg_valid;
    logic              msg_ready = 1'b0;
    logic [63:0]       msg_addr;
    logic [63:0]       msg_data;

    int n_run = 0;
    int n_fail = 0;
    logic [63:0] mdl = '0;
    logic [63:0] rv;

    always #10 clk = ~clk;

    lmn_notifier #(
        .NUM_SRC(NUM_SRC), .IDX_W(IDX_W), .REG_AW(REG_AW), .TRIG_BIT(TRIG_BIT)
    ) dut_i (
        .clk(clk), .rst_n(rst_n),
        .src_upd_valid(src_upd_valid), .src_upd_idx(src_upd_idx),
        .src_upd_state(src_upd_state), .src_err(src_err),
        .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .msg_valid(msg_valid), .msg_ready(msg_ready),
        .msg_addr(msg_addr), .msg_data(msg_data)
    );

    function automatic logic [63:0] exp_data(input int idx);
        return (64'(1) << TRIG_BIT) | {32'h0, IOFF[63:32]} | 64'(idx);
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [63:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [63:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic upd(input int idx, input logic st);
        @(negedge clk);
        src_upd_valid = 1'b1; src_upd_idx = IDX_W'(idx); src_upd_state = st;
        @(negedge clk);
        src_upd_valid = 1'b0;
    endtask

    task automatic take_msg(input string tag, input int idx);
        @(negedge clk);
        chk({tag, " valid"}, 64'(msg_valid), 64'd1);
        chk({tag, " addr"}, msg_addr, NADDR_OFF);
        chk({tag, " data"}, msg_data, exp_data(idx));
        msg_ready = 1'b1;
        @(negedge clk);
        msg_ready = 1'b0;
    endtask

    task automatic no_msg(input string tag);
        repeat (3) @(negedge clk);
        chk({tag, " no message"}, 64'(msg_valid), 64'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 msg_valid", 64'(msg_valid), 64'd0);
        chk("R1 src_err", 64'(src_err), 64'd0);
        rd(8'h58, rv); chk("R1 ctrl", rv, 64'd0);
        rd(8'h68, rv); chk("R1 naddr", rv, 64'd0);
        rd(8'h70, rv); chk("R1 ioff", rv, 64'd0);
        rd(8'h78, rv); chk("R1 level", rv, 64'd0);

        // R2 register access
        wr(8'h60, 64'hDEAD_BEEF_0000_1111);
        wr(8'h68, NADDR_ON);
        wr(8'h70, IOFF);
        rd(8'h60, rv); chk("R2 ebase", rv, 64'hDEAD_BEEF_0000_1111);
        rd(8'h68, rv); chk("R2 naddr", rv, NADDR_ON);
        rd(8'h70, rv); chk("R2 ioff", rv, IOFF);
        rd(8'h00, rv); chk("R2 unimpl 0x00", rv, '1);
        rd(8'h80, rv); chk("R2 unimpl 0x80", rv, '1);
        wr(8'h78, '1);
        rd(8'h78, rv); chk("R2 level write ignored", rv, 64'd0);

        // R3 R4 table walk
        for (int v = 0; v < 7; v++) begin
            int idx;
            logic st, em;
            idx = int'(VECS[v][6:2]);
            st  = VECS[v][1];
            em  = VECS[v][0];
            upd(idx, st);
            mdl[63-idx] = st;
            if (em) take_msg($sformatf("R4 vec%0d", v), idx);
            else    no_msg($sformatf("R4 vec%0d", v));
            rd(8'h78, rv); chk($sformatf("R3 level vec%0d", v), rv, mdl);
        end

        // R8 R9 queued sources under backpressure
        upd(7, 1'b1); mdl[63-7] = 1'b1;
        upd(3, 1'b1); mdl[63-3] = 1'b1;
        upd(9, 1'b1); mdl[63-9] = 1'b1;
        repeat (3) @(negedge clk);
        chk("R9 held valid", 64'(msg_valid), 64'd1);
        chk("R9 held data", msg_data, exp_data(7));
        take_msg("R8 first", 7);
        take_msg("R8 second", 3);
        take_msg("R8 third", 9);
        no_msg("R8 drained");

        // R5 notify disabled
        wr(8'h68, NADDR_OFF);
        upd(10, 1'b1); mdl[63-10] = 1'b1;
        no_msg("R5 disabled");
        rd(8'h78, rv); chk("R5 level", rv, mdl);
        wr(8'h68, NADDR_ON);
        no_msg("R5 discarded");

        // R6 method bit
        wr(8'h58, 64'h8000_0000_0000_0000);
        upd(12, 1'b1);
        no_msg("R6 method");
        rd(8'h78, rv); chk("R6 level frozen", rv, mdl);
        wr(8'h58, 64'h0);
        rd(8'h78, rv); chk("R6 level after", rv, mdl);
        upd(12, 1'b1); mdl[63-12] = 1'b1;
        take_msg("R6 rise after clear", 12);

        // R10 out-of-range index
        @(negedge clk);
        src_upd_valid = 1'b1; src_upd_idx = 5'd20; src_upd_state = 1'b1;
        @(negedge clk);
        src_upd_valid = 1'b0;
        chk("R10 err pulse", 64'(src_err), 64'd1);
        @(negedge clk);
        chk("R10 err one cycle", 64'(src_err), 64'd0);
        upd(31, 1'b1);
        chk("R10 err idx31", 64'(src_err), 64'd1);
        no_msg("R10");
        rd(8'h78, rv); chk("R10 level unchanged", rv, mdl);

        // R7 source reset
        upd(1, 1'b1);
        upd(2, 1'b1);
        wr(8'h58, 64'h4000_0000_0000_0001);
        rd(8'h58, rv); chk("R7 ctrl stored", rv, 64'h1);
        rd(8'h78, rv); chk("R7 level cleared", rv, 64'd0);
        take_msg("R7 in-flight kept", 1);
        no_msg("R7 pending cleared");
        upd(2, 1'b1);
        take_msg("R7 rise after clear", 2);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule